// File: doc/BRIEF.md
# Security ID Region Controller

This block holds a 256-bit identification store that can only be programmed once, organised as sixteen 16-bit words. The lower eight words are the factory half. Its value comes from a parameter, and the block never changes it. The upper eight words are the user half. They come out of reset with every bit set. A write request can only clear bits in them, and a lock command freezes them for good. There is no erase path into either half.

The block is driven by an upstream command decoder through three one-cycle strobes: read, word program and lock. A word address and write data travel with them. A read returns the word one cycle later, with a valid flag.

A program occupies the store for a parameterised number of cycles. During that time a status bit inverts on every read, and this toggling is the only indication that a program has finished. Requests that cannot be honoured have no effect, and the block raises a reject flag for one cycle.

Top module: `sec_id_region`

## Requirements
- R1: After reset `busy`, `reject`, `toggle` and `rdValid` are all 0.
- R2: A read strobe at a clock edge makes `rdValid` high for one cycle after that edge. `rdData` then holds the addressed word. For addresses 0 to 7 this is bits [16*a+15:16*a] of the factory parameter.
- R3: Before any program, every user word (addresses 8 to 15) reads as 16'hFFFF.
- R4: An accepted program to a user address raises `busy` for exactly BUSY_CYCLES cycles. When `busy` falls, the word holds the bitwise AND of its previous value and the write data.
- R5: Programming never sets a bit. Programming a word again with ones leaves its cleared bits at 0.
- R6: While `busy` is high, each read strobe inverts `toggle`. While `busy` is low, `toggle` does not change.
- R7: A program to a factory address (0 to 7) starts no busy period and changes no word. It raises `reject` for exactly one cycle after the request edge.
- R8: After an accepted lock strobe, every program to a user address is rejected and leaves the word unchanged. An accepted lock itself does not raise `reject` or `busy`.
- R9: A lock strobe while the user half is already locked raises `reject`.
- R10: A program or lock strobe while `busy` is high is rejected and has no effect. A program strobe in the same cycle as a lock strobe takes precedence, and the lock is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; presets the user half to all ones and clears the lock |
| rdReq | input | 1 | Read strobe |
| progReq | input | 1 | Word program strobe |
| lockReq | input | 1 | User-half lock strobe |
| addr | input | 4 | Word address; bit 3 selects the user half |
| wrData | input | 16 | Program data |
| rdData | output | 16 | Read data |
| rdValid | output | 1 | Read data valid, one cycle |
| busy | output | 1 | Program in progress |
| toggle | output | 1 | Status bit that inverts on reads during a program |
| reject | output | 1 | One-cycle pulse for a refused request |

## Verification
The read path is run across all eight factory words and several blank user words. This shows that the parameter slicing and the half-select bit are correct. Two programs to the same word are used next. The first clears a pattern from all ones, and the second writes a value with a different set of ones. The second result shows whether the store ANDs old and new data or simply overwrites. Reads issued while a program is running show that `toggle` alternates and that the old data is still returned before the commit. Refused requests are then sent one at a time: a factory address, a request during a program, a program after lock, and a second lock. Read-back after each one shows that the rejected request changed nothing.

// File: rtl/sec_id_pkg.sv
package sec_id_pkg;

  // Control-to-datapath strobes, all single-cycle
  typedef struct packed {
    logic load;     // capture pending address and data of an accepted program
    logic commit;   // merge pending data into the user word
    logic setLock;  // freeze the user half
    logic flip;     // invert the status toggle
  } idStrobe_t;

endpackage

// File: rtl/sec_id_ctrl.sv
module sec_id_ctrl
  import sec_id_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       progReq,
  input  logic       lockReq,
  input  logic       userSel,
  input  logic       userLocked,
  output idStrobe_t  strb,
  output logic       busy,
  output logic       reject
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cntQ;
  logic             busyQ;
  logic             rejectQ;
  logic             progOk;
  logic             progBad;
  logic             lockTry;
  logic             lockOk;
  logic             lockBad;
  logic             lastCycle;

  always_comb begin
    progOk    = progReq && !busyQ && userSel && !userLocked;
    progBad   = progReq && !progOk;
    lockTry   = lockReq && !progReq;
    lockOk    = lockTry && !busyQ && !userLocked;
    lockBad   = lockTry && !lockOk;
    lastCycle = busyQ && (cntQ == CNT_W'(1));

    strb.load    = progOk;
    strb.commit  = lastCycle;
    strb.setLock = lockOk;
    strb.flip    = rdReq && busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      cntQ    <= '0;
      rejectQ <= 1'b0;
    end else begin
      rejectQ <= progBad || lockBad;
      if (progOk) begin
        busyQ <= 1'b1;
        cntQ  <= CNT_W'(BUSY_CYCLES);
      end else if (busyQ) begin
        cntQ <= cntQ - CNT_W'(1);
        if (lastCycle) busyQ <= 1'b0;
      end
    end
  end

  assign busy   = busyQ;
  assign reject = rejectQ;

  AST_BUSY_FROM_PROG: assert property (@(posedge clk) disable iff (!rstN) $rose(busyQ) |-> $past(progReq)); // R4
  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN) strb.commit |=> !busyQ); // R4

endmodule

// File: rtl/sec_id_dp.sv
module sec_id_dp
  import sec_id_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          ID_BITS    = 256,
  parameter logic [ID_BITS/2-1:0] FACTORY_ID = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  idStrobe_t                    strb,
  input  logic                         rdReq,
  input  logic [$clog2(ID_BITS/DATA_W)-1:0] addr,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  output logic                         rdValid,
  output logic                         toggle,
  output logic                         userLocked
);

  localparam int WORDS     = ID_BITS / DATA_W;
  localparam int ADDR_W    = $clog2(WORDS);
  localparam int SEG_WORDS = WORDS / 2;
  localparam int IDX_W     = ADDR_W - 1;

  logic [SEG_WORDS*DATA_W-1:0] userFlat;
  logic [IDX_W-1:0]            pendIdx;
  logic [DATA_W-1:0]           pendData;
  logic                        lockQ;
  logic [DATA_W-1:0]           rdDataQ;
  logic                        rdValidQ;
  logic                        toggleQ;
  logic [IDX_W-1:0]            rdIdx;
  logic                        rdUser;
  logic [DATA_W-1:0]           rdWord;

  // One storage word per user location
  for (genvar w = 0; w < SEG_WORDS; w++) begin : gUser
    logic [DATA_W-1:0] wordQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordQ <= '1;
      end else if (strb.commit && pendIdx == IDX_W'(w)) begin
        wordQ <= wordQ & pendData;
      end
    end

    assign userFlat[w*DATA_W +: DATA_W] = wordQ;

    AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN) (wordQ & ~$past(wordQ)) == '0); // R5
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendIdx  <= '0;
      pendData <= '0;
      lockQ    <= 1'b0;
      toggleQ  <= 1'b0;
    end else begin
      if (strb.load) begin
        pendIdx  <= addr[IDX_W-1:0];
        pendData <= wrData;
      end
      if (strb.setLock) lockQ <= 1'b1;
      if (strb.flip) toggleQ <= ~toggleQ;
    end
  end

  always_comb begin
    rdIdx  = addr[IDX_W-1:0];
    rdUser = addr[ADDR_W-1];
    if (rdUser) rdWord = userFlat[int'(rdIdx)*DATA_W +: DATA_W];
    else        rdWord = FACTORY_ID[int'(rdIdx)*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= rdReq;
      if (rdReq) rdDataQ <= rdWord;
    end
  end

  assign rdData     = rdDataQ;
  assign rdValid    = rdValidQ;
  assign toggle     = toggleQ;
  assign userLocked = lockQ;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN) lockQ |=> lockQ); // R8
  AST_NO_COMMIT_LOCKED: assert property (@(posedge clk) disable iff (!rstN) strb.commit |-> !lockQ); // R8

endmodule

// File: rtl/sec_id_region.sv
module sec_id_region
  import sec_id_pkg::*;
#(
  parameter int                   DATA_W      = 16,
  parameter int                   ID_BITS     = 256,
  parameter int                   BUSY_CYCLES = 8,
  parameter logic [ID_BITS/2-1:0] FACTORY_ID  = 128'h0123_4567_89AB_CDEF_F00D_CAFE_1357_2468
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               rdReq,
  input  logic                               progReq,
  input  logic                               lockReq,
  input  logic [$clog2(ID_BITS/DATA_W)-1:0]  addr,
  input  logic [DATA_W-1:0]                  wrData,
  output logic [DATA_W-1:0]                  rdData,
  output logic                               rdValid,
  output logic                               busy,
  output logic                               toggle,
  output logic                               reject
);

  localparam int ADDR_W = $clog2(ID_BITS / DATA_W);

  idStrobe_t strb;
  logic      userLocked;

  sec_id_ctrl #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdReq      (rdReq),
    .progReq    (progReq),
    .lockReq    (lockReq),
    .userSel    (addr[ADDR_W-1]),
    .userLocked (userLocked),
    .strb       (strb),
    .busy       (busy),
    .reject     (reject)
  );

  sec_id_dp #(
    .DATA_W     (DATA_W),
    .ID_BITS    (ID_BITS),
    .FACTORY_ID (FACTORY_ID)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdReq      (rdReq),
    .addr       (addr),
    .wrData     (wrData),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .toggle     (toggle),
    .userLocked (userLocked)
  );

  AST_TOGGLE_IDLE: assert property (@(posedge clk) disable iff (!rstN) !busy |=> $stable(toggle)); // R6
  AST_REJECT_EXCL: assert property (@(posedge clk) disable iff (!rstN) reject |-> !$rose(busy)); // R7

endmodule

// File: tb/sec_id_region_test.sv
module sec_id_region_test;

  localparam int           BUSY = 8;
  localparam logic [127:0] FID  = 128'h0123_4567_89AB_CDEF_F00D_CAFE_1357_2468;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdReq = 1'b0;
  logic        progReq = 1'b0;
  logic        lockReq = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rdValid, busy, toggle, reject;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  sec_id_region #(.BUSY_CYCLES(BUSY), .FACTORY_ID(FID)) uut (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .progReq(progReq), .lockReq(lockReq),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .busy(busy), .toggle(toggle), .reject(reject)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pop the expected word whenever the design reports read data
  always @(negedge clk) begin : monitor
    logic [15:0] e;
    string       t;
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected read data", {16'h0, rdData}, 32'h0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(rdData == e, t, {16'h0, rdData}, {16'h0, e});
      end
    end
  end

  task automatic rdWord(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    rdReq = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic startProg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a;
    wrData = d;
    progReq = 1'b1;
    @(negedge clk);
    progReq = 1'b0;
  endtask

  task automatic pulseLock();
    @(negedge clk);
    lockReq = 1'b1;
    @(negedge clk);
    lockReq = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin : driver
    int n;
    logic t0;
    logic t1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(reject == 1'b0, "R1 reject after reset", reject, 0);
    chk(toggle == 1'b0, "R1 toggle after reset", toggle, 0);
    chk(rdValid == 1'b0, "R1 rdValid after reset", rdValid, 0);

    // R2 factory words
    for (int i = 0; i < 8; i++) rdWord(4'(i), FID[i*16 +: 16], "R2 factory word");

    // R3 blank user words
    for (int i = 8; i < 16; i += 3) rdWord(4'(i), 16'hFFFF, "R3 blank user word");

    // R4 program and busy length
    startProg(4'd9, 16'hA5F0);
    chk(busy == 1'b1, "R4 busy after accept", busy, 1);
    waitIdle(n);
    chk(n == BUSY, "R4 busy length", n, BUSY);
    rdWord(4'd9, 16'hA5F0, "R4 programmed word");

    // R5 and R6: second program with AND merge, toggle during busy
    t0 = toggle;
    startProg(4'd9, 16'h0FFF);
    for (int k = 1; k <= 3; k++) begin
      rdWord(4'd9, 16'hA5F0, "R6 old data during busy");
      chk(toggle == (t0 ^ k[0]), "R6 toggle alternates", toggle, t0 ^ k[0]);
    end
    waitIdle(n);
    t1 = toggle;
    rdWord(4'd9, 16'h05F0, "R5 bits only clear");
    chk(toggle == t1, "R6 toggle stable when idle", toggle, t1);
    rdWord(4'd9, 16'h05F0, "R5 bits only clear again");
    chk(toggle == t1, "R6 toggle stable when idle again", toggle, t1);

    // R7 factory write refused
    startProg(4'd3, 16'h0000);
    chk(reject == 1'b1, "R7 reject on factory program", reject, 1);
    chk(busy == 1'b0, "R7 no busy on factory program", busy, 0);
    @(negedge clk);
    chk(reject == 1'b0, "R7 reject lasts one cycle", reject, 0);
    rdWord(4'd3, FID[3*16 +: 16], "R7 factory word unchanged");

    // R10 requests during busy
    startProg(4'd10, 16'h1234);
    startProg(4'd11, 16'h0000);
    chk(reject == 1'b1, "R10 program during busy rejected", reject, 1);
    pulseLock();
    chk(reject == 1'b1, "R10 lock during busy rejected", reject, 1);
    waitIdle(n);
    rdWord(4'd10, 16'h1234, "R10 first program completes");
    rdWord(4'd11, 16'hFFFF, "R10 busy program ignored");
    startProg(4'd12, 16'h00FF);
    chk(reject == 1'b0, "R10 lock during busy was ignored", reject, 0);
    waitIdle(n);
    rdWord(4'd12, 16'h00FF, "R10 program after dropped lock");

    // R10 program wins over a simultaneous lock
    @(negedge clk);
    addr = 4'd13;
    wrData = 16'hFF00;
    progReq = 1'b1;
    lockReq = 1'b1;
    @(negedge clk);
    progReq = 1'b0;
    lockReq = 1'b0;
    chk(busy == 1'b1, "R10 program takes precedence", busy, 1);
    waitIdle(n);
    rdWord(4'd13, 16'hFF00, "R10 precedence program result");
    startProg(4'd14, 16'h0F0F);
    chk(reject == 1'b0, "R10 simultaneous lock dropped", reject, 0);
    waitIdle(n);

    // R8 lock
    pulseLock();
    chk(reject == 1'b0, "R8 accepted lock no reject", reject, 0);
    chk(busy == 1'b0, "R8 accepted lock no busy", busy, 0);
    startProg(4'd12, 16'h0000);
    chk(reject == 1'b1, "R8 program after lock rejected", reject, 1);
    chk(busy == 1'b0, "R8 no busy after lock", busy, 0);
    rdWord(4'd12, 16'h00FF, "R8 locked word unchanged");
    startProg(4'd15, 16'h0000);
    chk(reject == 1'b1, "R8 blank word program rejected", reject, 1);
    rdWord(4'd15, 16'hFFFF, "R8 locked blank word unchanged");

    // R9 second lock
    pulseLock();
    chk(reject == 1'b1, "R9 second lock rejected", reject, 1);

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R2 all reads returned", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule